// File: doc/BRIEF.md
# Flash Sector-Erase Command Sequencer

This block is the command front end of a parallel NOR flash model, limited to sector erase. It watches single-cycle write strokes on a shared address/data bus. A fixed six-write unlock-and-setup sequence arms it. The last write of that sequence names the first sector to erase. An acceptance window then opens, and further sector commands may join the erase buffer in any order. Each one restarts the window. When the window runs out, a counter-driven busy period stands in for the embedded erase. At its end every buffered sector reads as erased.

While the window or the erase is running, reads return a status byte instead of array data. An erase-suspend command freezes the busy counter, and sectors outside the buffer can then be read. A resume command continues the busy count from where it stopped. The active-low reset is the hardware reset. It abandons any sequence or erase, empties the buffer, and returns the model array to its unerased fill pattern. Sector erased flags hold until that reset.

The controller has nine states:
- ST_READ: array read.
- ST_UNL1, ST_UNL2: first unlock pair received.
- ST_SETUP: setup write seen.
- ST_UNL3, ST_UNL4: second unlock pair received.
- ST_WINDOW: acceptance window open.
- ST_ERASE: busy period running.
- ST_SUSPEND: erase suspended.

Its transitions are:
- READ to UNL1 on the first unlock write.
- UNL1 to UNL2 on the second unlock write.
- UNL2 to SETUP on the setup write.
- SETUP to UNL3 and UNL3 to UNL4 on the repeated unlock pair.
- UNL4 to WINDOW on a sector command.
- Any of UNL1 to UNL4 or SETUP back to READ on a mismatching write.
- WINDOW to WINDOW on a further sector command, which restarts the window.
- WINDOW to READ on a stray write.
- WINDOW to ERASE when the window expires.
- WINDOW to SUSPEND and ERASE to SUSPEND on a suspend write.
- SUSPEND to ERASE on a resume write.
- ERASE to READ when the busy count completes.
- Every state to READ on reset.

Top module: `nor_erase_seq`

## Requirements
- R1: A write is one clock with `wr_en` high. The address carries the sector number in its top `SEC_W` bits (bits 13:11 by default) and a word offset in bits 10:0. The erase sequence is six writes in this order: 0xAA at offset 0x555, 0x55 at offset 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, and then 0x30 at any offset. That last write adds its sector to the buffer and opens the window.
- R2: Any write that does not match the next expected step of the sequence returns the block to array read, and nothing is erased.
- R3: The window stays open for `WIN_CYC` clock cycles after the clock edge that captured the last accepted sector command. Each further 0x30 write during the window adds its sector and restarts the full window.
- R4: While the window is open, a write whose data is neither 0x30 nor 0xB0 empties the buffer and returns the block to array read without erasing.
- R5: Status bit 3 reads 0 while the window is open. It reads 1 during the busy period and while suspended.
- R6: During the busy period, only a 0xB0 write is acted on. Every other write is ignored, and the busy period keeps its length.
- R7: The busy period lasts `ERASE_CYC` unsuspended cycles, after which the block returns to array read. A buffered sector then reads 0xFF, and a sector never erased reads the fill byte `FILL` (0xA5 by default).
- R8: A status byte has bit 7 = 0, bit 6 = toggle, bit 3 as in R5, and all other bits 0. The toggle is 0 on the first status read after array read and flips on every status read after that.
- R9: A 0xB0 write in the window or the busy period suspends the erase and freezes the busy count. While suspended, non-buffered sectors return array data and buffered sectors return status. A 0x30 write resumes, and the remaining busy count is then completed.
- R10: A low `rst_n` at a clock edge abandons any sequence, window or erase and returns the block to array read. The buffer is emptied, every sector returns to the fill byte, and `rd_data` is 0x00.
- R11: A read is one clock with `rd_en` high. `rd_data` shows the result from the following cycle and holds it until the next read.
- R12: A sector's erased state is kept across later erase sequences and ends only at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 11+SEC_W | Shared address: sector in top bits, word offset in bits 10:0 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read result (array byte or status) |

## Verification
The bench places reads at the exact last window cycle and first busy cycle, and at the last busy cycle and first read-mode cycle. A window of the wrong length, or a busy period of the wrong length, therefore shows up as a wrong status bit 3 or as status where 0xFF was due. A second sector command placed late in the window catches a design that does not restart the window: that design would already report busy. A stray write in the window, unlock-like writes during the busy period, and a long suspend catch a design that ignores the abort, aborts on junk, or keeps counting while frozen. Each of these leaves an erased sector reading the fill byte, or the reverse. Random multi-sector queues with repeats and random gaps check that the buffer collects exactly the named sectors.

// File: rtl/nes_pkg.sv
`timescale 1ns/1ps
package nes_pkg;

    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] OFF_A = 11'h555;
    localparam logic [CMD_AW-1:0] OFF_B = 11'h2AA;

    localparam logic [7:0] D_UNL_A = 8'hAA;
    localparam logic [7:0] D_UNL_B = 8'h55;
    localparam logic [7:0] D_SETUP = 8'h80;
    localparam logic [7:0] D_SECT  = 8'h30;
    localparam logic [7:0] D_SUSP  = 8'hB0;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_SETUP,
        ST_UNL3,
        ST_UNL4,
        ST_WINDOW,
        ST_ERASE,
        ST_SUSPEND
    } nes_state_e;

endpackage

// File: rtl/nes_cycle_timer.sv
`timescale 1ns/1ps
module nes_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || done) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3 / R7: the count never passes its limit
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/nes_sector_buf.sv
`timescale 1ns/1ps
module nes_sector_buf #(
    parameter int SEC_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     add,
    input  logic [SEC_W-1:0]         add_sec,
    input  logic                     clr,
    input  logic                     commit,
    output logic [(1<<SEC_W)-1:0]    pend,
    output logic [(1<<SEC_W)-1:0]    erased
);
    localparam int NSEC = 1 << SEC_W;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[s]   <= 1'b0;
                erased[s] <= 1'b0;
            end else begin
                if (commit) begin
                    erased[s] <= erased[s] | pend[s];
                    pend[s]   <= 1'b0;
                end else if (clr) begin
                    pend[s] <= 1'b0;
                end else if (add && (add_sec == SEC_W'(s))) begin
                    pend[s] <= 1'b1;
                end
            end
        end
    end

    // R7: an erase only completes with something in the buffer
    a_r7_commit_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (pend != '0));

    // R12: erased sectors stay erased until reset
    a_r12_erased_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((erased & $past(erased)) == $past(erased)));

endmodule

// File: rtl/nes_read_port.sv
`timescale 1ns/1ps
module nes_read_port
    import nes_pkg::*;
#(
    parameter int         SEC_W = 3,
    parameter logic [7:0] FILL  = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  nes_state_e            state,
    input  logic                  rd_en,
    input  logic [SEC_W-1:0]      rd_sec,
    input  logic [(1<<SEC_W)-1:0] pend,
    input  logic [(1<<SEC_W)-1:0] erased,
    output logic [7:0]            rd_data
);
    logic       tgl;
    logic       dq3;
    logic       status_rd;
    logic [7:0] stat_byte;
    logic [7:0] array_byte;

    always_comb begin
        dq3        = (state == ST_ERASE) || (state == ST_SUSPEND);
        status_rd  = rd_en && ((state == ST_WINDOW) || (state == ST_ERASE) ||
                               ((state == ST_SUSPEND) && pend[rd_sec]));
        stat_byte  = {1'b0, tgl, 2'b00, dq3, 3'b000};
        array_byte = erased[rd_sec] ? 8'hFF : FILL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
            tgl     <= 1'b0;
        end else begin
            if (state == ST_READ) begin
                tgl <= 1'b0;
            end else if (status_rd) begin
                tgl <= ~tgl;
            end
            if (rd_en) begin
                rd_data <= status_rd ? stat_byte : array_byte;
            end
        end
    end

    // R8: status reads never show bit 7 set
    a_r8_dq7_low: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> !rd_data[7]);

    // R8: back-to-back status reads alternate bit 6
    a_r8_dq6_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd ##1 status_rd) |=> (rd_data[6] != $past(rd_data[6])));

    // R5: status read in the window shows bit 3 clear
    a_r5_dq3_window: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && state == ST_WINDOW) |=> !rd_data[3]);

endmodule

// File: rtl/nes_cmd_fsm.sv
`timescale 1ns/1ps
module nes_cmd_fsm
    import nes_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] wr_off,
    input  logic [7:0]        wr_data,
    input  logic              win_done,
    input  logic              ers_done,
    output nes_state_e        state,
    output logic              buf_add,
    output logic              buf_clr,
    output logic              buf_commit,
    output logic              win_restart
);
    nes_state_e state_n;
    logic       w_unl_a;
    logic       w_unl_b;
    logic       w_setup;
    logic       w_sect;
    logic       w_susp;

    always_comb begin
        w_unl_a = wr_en && (wr_off == OFF_A) && (wr_data == D_UNL_A);
        w_unl_b = wr_en && (wr_off == OFF_B) && (wr_data == D_UNL_B);
        w_setup = wr_en && (wr_off == OFF_A) && (wr_data == D_SETUP);
        w_sect  = wr_en && (wr_data == D_SECT);
        w_susp  = wr_en && (wr_data == D_SUSP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_READ:    if (w_unl_a) state_n = ST_UNL1;
            ST_UNL1:    if (w_unl_b) state_n = ST_UNL2;
                        else if (wr_en) state_n = ST_READ;
            ST_UNL2:    if (w_setup) state_n = ST_SETUP;
                        else if (wr_en) state_n = ST_READ;
            ST_SETUP:   if (w_unl_a) state_n = ST_UNL3;
                        else if (wr_en) state_n = ST_READ;
            ST_UNL3:    if (w_unl_b) state_n = ST_UNL4;
                        else if (wr_en) state_n = ST_READ;
            ST_UNL4:    if (w_sect) state_n = ST_WINDOW;
                        else if (wr_en) state_n = ST_READ;
            ST_WINDOW:  if (w_sect) state_n = ST_WINDOW;
                        else if (w_susp) state_n = ST_SUSPEND;
                        else if (wr_en) state_n = ST_READ;
                        else if (win_done) state_n = ST_ERASE;
            ST_ERASE:   if (w_susp) state_n = ST_SUSPEND;
                        else if (ers_done) state_n = ST_READ;
            ST_SUSPEND: if (w_sect) state_n = ST_ERASE;
            default:    state_n = ST_READ;
        endcase
    end

    always_comb begin
        buf_add     = 1'b0;
        buf_clr     = 1'b0;
        buf_commit  = 1'b0;
        win_restart = 1'b0;
        unique case (state)
            ST_UNL4: begin
                buf_add = w_sect;
            end
            ST_WINDOW: begin
                buf_add     = w_sect;
                win_restart = w_sect;
                buf_clr     = wr_en && !w_sect && !w_susp;
            end
            ST_ERASE: begin
                buf_commit = ers_done && !w_susp;
            end
            default: begin
            end
        endcase
    end

    // R2: a mismatching write inside the unlock sequence returns to read mode
    a_r2_unlock_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNL1 && wr_en && !w_unl_b) |=> (state == ST_READ));

    // R4: a stray write in the window aborts to read mode
    a_r4_stray_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && wr_en && wr_data != D_SECT && wr_data != D_SUSP)
        |=> (state == ST_READ));

    // R6: non-suspend writes during the busy period leave it running
    a_r6_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && wr_en && wr_data != D_SUSP && !ers_done)
        |=> (state == ST_ERASE));

endmodule

// File: rtl/nor_erase_seq.sv
`timescale 1ns/1ps
module nor_erase_seq
    import nes_pkg::*;
#(
    parameter int         SEC_W     = 3,
    parameter int         WIN_CYC   = 2500,
    parameter int         ERASE_CYC = 5000,
    parameter logic [7:0] FILL      = 8'hA5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [CMD_AW+SEC_W-1:0]   addr,
    input  logic [7:0]                wr_data,
    output logic [7:0]                rd_data
);
    localparam int ADDR_W = CMD_AW + SEC_W;
    localparam int NSEC   = 1 << SEC_W;

    nes_state_e       state;
    logic             buf_add;
    logic             buf_clr;
    logic             buf_commit;
    logic             win_restart;
    logic             win_done;
    logic             ers_done;
    logic             win_clr;
    logic             win_run;
    logic             ers_clr;
    logic             ers_run;
    logic [SEC_W-1:0] sec;
    logic [NSEC-1:0]  pend;
    logic [NSEC-1:0]  erased;

    always_comb begin
        sec     = addr[ADDR_W-1 -: SEC_W];
        win_run = (state == ST_WINDOW);
        win_clr = !win_run || win_restart;
        ers_clr = !((state == ST_ERASE) || (state == ST_SUSPEND));
        ers_run = (state == ST_ERASE) && !(wr_en && wr_data == D_SUSP);
    end

    nes_cmd_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_off      (addr[CMD_AW-1:0]),
        .wr_data     (wr_data),
        .win_done    (win_done),
        .ers_done    (ers_done),
        .state       (state),
        .buf_add     (buf_add),
        .buf_clr     (buf_clr),
        .buf_commit  (buf_commit),
        .win_restart (win_restart)
    );

    nes_cycle_timer #(.LIMIT(WIN_CYC)) i_win_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .run   (win_run),
        .done  (win_done)
    );

    nes_cycle_timer #(.LIMIT(ERASE_CYC)) i_ers_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ers_clr),
        .run   (ers_run),
        .done  (ers_done)
    );

    nes_sector_buf #(.SEC_W(SEC_W)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (buf_add),
        .add_sec (sec),
        .clr     (buf_clr),
        .commit  (buf_commit),
        .pend    (pend),
        .erased  (erased)
    );

    nes_read_port #(.SEC_W(SEC_W), .FILL(FILL)) i_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .rd_en   (rd_en),
        .rd_sec  (sec),
        .pend    (pend),
        .erased  (erased),
        .rd_data (rd_data)
    );

    // R10: hardware reset always lands in read mode
    a_r10_reset_to_read: assert property (@(posedge clk)
        !rst_n |=> (state == ST_READ));

    // R9: suspended state keeps the buffer intact
    a_r9_suspend_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPEND) |=> (pend == $past(pend)));

endmodule

// File: tb/test_nor_erase_seq.sv
`timescale 1ns/1ps
module test_nor_erase_seq;

    localparam int SEC_W  = 3;
    localparam int WIN    = 16;
    localparam int ERS    = 40;
    localparam int NSEC   = 1 << SEC_W;
    localparam logic [7:0] FILLB = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [13:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    logic [NSEC-1:0] exp_erased = '0;

    always #10 clk = ~clk;

    nor_erase_seq #(.SEC_W(SEC_W), .WIN_CYC(WIN), .ERASE_CYC(ERS), .FILL(FILLB))
        i_nor_erase_seq (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
            .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

    function automatic logic [7:0] exp_array(input int s);
        return exp_erased[s] ? 8'hFF : FILLB;
    endfunction

    function automatic logic [7:0] exp_status(input logic dq3, input logic tg);
        return {1'b0, tg, 2'b00, dq3, 3'b000};
    endfunction

    function automatic logic [13:0] sa(input int s);
        return {3'(s), 11'h000};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [13:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic erase_cmd(input int s);
        wr(14'h555, 8'hAA);
        wr(14'h2AA, 8'h55);
        wr(14'h555, 8'h80);
        wr(14'h555, 8'hAA);
        wr(14'h2AA, 8'h55);
        wr(sa(s), 8'h30);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wt(3);
        rst_n = 1'b1;
        exp_erased = '0;
        wt(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        do_reset();

        // R10 / R11: reset state
        chk("R10 rd_data after reset", rd_data, 8'h00);
        rd(sa(0), v); chk("R11 array read after reset", v, FILLB);

        // R2: broken sequence, then a bare sector command
        wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(14'h555, 8'h90);
        rd(sa(1), v); chk("R2 read mode after mismatch", v, FILLB);
        wr(sa(1), 8'h30);
        wt(WIN + ERS + 5);
        rd(sa(1), v); chk("R2 nothing erased", v, FILLB);

        // R3 / R5 / R7 / R8: exact window and busy boundaries on sector 2
        erase_cmd(2);
        wt(WIN - 2);
        rd(sa(2), v); chk("R5 window bit3 low, first toggle", v, exp_status(1'b0, 1'b0));
        rd(sa(2), v); chk("R3 last window cycle", v, exp_status(1'b0, 1'b1));
        rd(sa(2), v); chk("R5 first busy cycle bit3 high", v, exp_status(1'b1, 1'b0));
        wt(ERS - 2);
        rd(sa(2), v); chk("R7 last busy cycle", v, exp_status(1'b1, 1'b1));
        exp_erased[2] = 1'b1;
        rd(sa(2), v); chk("R7 erased sector reads FF", v, 8'hFF);
        rd(sa(3), v); chk("R7 other sector untouched", v, FILLB);

        // R4: stray write inside the window
        erase_cmd(6);
        wr(14'h555, 8'hF0);
        rd(sa(6), v); chk("R4 stray write aborts", v, FILLB);
        wt(WIN + ERS + 5);
        rd(sa(6), v); chk("R4 nothing erased", v, FILLB);

        // R3: second sector late in the window restarts it
        erase_cmd(0);
        wt(WIN - 4);
        wr(sa(1), 8'h30);
        wt(WIN - 3);
        rd(sa(0), v); chk("R3 window restarted", v, exp_status(1'b0, 1'b0));
        wt(WIN + ERS + 5);
        exp_erased[0] = 1'b1; exp_erased[1] = 1'b1;
        rd(sa(0), v); chk("R3 first queued sector", v, 8'hFF);
        rd(sa(1), v); chk("R3 second queued sector", v, 8'hFF);
        rd(sa(2), v); chk("R12 earlier erase kept", v, 8'hFF);

        // R6: junk writes while busy
        erase_cmd(5);
        wt(WIN + 2);
        wr(14'h555, 8'hAA); wr(14'h2AA, 8'h55); wr(14'h555, 8'h80);
        rd(sa(5), v); chk("R6 still busy after junk", v & 8'h88, 8'h08);
        wt(ERS);
        exp_erased[5] = 1'b1;
        rd(sa(5), v); chk("R6 erase completed", v, 8'hFF);

        // R9: suspend, freeze, resume
        erase_cmd(3);
        wt(WIN + 5);
        wr(sa(3), 8'hB0);
        rd(sa(4), v); chk("R9 non-buffered sector readable", v, FILLB);
        rd(sa(3), v); chk("R9 buffered sector gives status", v & 8'h88, 8'h08);
        wt(ERS * 3);
        rd(sa(3), v); chk("R9 count frozen", v & 8'h88, 8'h08);
        wr(sa(3), 8'h30);
        wt(ERS + 5);
        exp_erased[3] = 1'b1;
        rd(sa(3), v); chk("R9 resumed erase completes", v, 8'hFF);
        rd(sa(4), v); chk("R9 neighbour untouched", v, FILLB);

        // R10: reset in the middle of an erase
        erase_cmd(7);
        wt(WIN + 5);
        do_reset();
        rd(sa(7), v); chk("R10 aborted sector not erased", v, FILLB);
        rd(sa(2), v); chk("R10 array back to fill", v, FILLB);
        wt(ERS + 5);
        rd(sa(7), v); chk("R10 no late erase", v, FILLB);

        // R1 / R3 / R12: random sector queues with random gaps
        void'($urandom(32'd2024));
        for (int round = 0; round < 6; round++) begin
            int n;
            int s;
            n = 1 + int'($urandom % NSEC);
            s = int'($urandom % NSEC);
            erase_cmd(s);
            exp_erased[s] = 1'b1;
            for (int k = 1; k < n; k++) begin
                wt(int'($urandom % (WIN - 3)));
                s = int'($urandom % NSEC);
                wr(sa(s), 8'h30);
                exp_erased[s] = 1'b1;
            end
            wt(WIN + ERS + 5);
            for (int q = 0; q < NSEC; q++) begin
                rd(sa(q), v);
                chk("R1 random queue sector state", v, exp_array(q));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule